// File: doc/BRIEF.md
# Three-Port Register File with Same-Cycle Forwarding

This block holds the architectural integer registers of a pipelined datapath: 32 words of 32 bits, two read ports and one write port, each port selecting its word by a 5-bit register number. The write port has an enable and a data word, and the storage updates on the rising clock edge. Both read ports are combinational. Each decodes its register number through a full multiplexer over the array, so a read needs no clock.

The write-back stage and the decode stage of a pipeline use the file in the same cycle. A read whose register number matches the register being written in that cycle therefore returns the incoming data and not the stored word. In effect the write happens in the first half of the cycle and the read in the second. Register 0 is a constant zero: it has no storage, writes to it are dropped, and it never takes the forwarded value. A synchronous active-high reset blocks the write port while it is high. It does not clear the stored words.

Top module: `trio_regfile`

## Requirements
- R1: The file holds 32 registers of 32 bits, has two independent read ports (A and B) and one write port, and every port is addressed by a 5-bit register number.
- R2: When `wr_en` is 1 and `rst` is 0 at a rising clock edge, and `wr_idx` is not 0, `wr_word` is stored in register `wr_idx`. From then on both read ports return it until that register is written again.
- R3: Register 0 reads as 0 on both ports at all times, including during reset. A write to register 0 is discarded.
- R4: While `wr_en` is 1 and `rst` is 0, a read port whose address equals a nonzero `wr_idx` returns `wr_word` in that same cycle, before the clock edge.
- R5: Forwarding never applies to register 0. Writing a nonzero word to register 0 while reading register 0 returns 0.
- R6: While `wr_en` is 0, no register changes, whatever values `wr_idx` and `wr_word` hold.
- R7: The read ports are combinational. A change of `rd_idx_a` or `rd_idx_b` changes the matching output within the same clock phase, with no clock edge.
- R8: While `rst` is 1 the write port is ignored: nothing is stored and nothing is forwarded. Reset does not clear registers that were already written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks the write port |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number to write |
| wr_word | input | 32 | Data to write |
| rd_idx_a | input | 5 | Register number for read port A |
| rd_idx_b | input | 5 | Register number for read port B |
| rd_word_a | output | 32 | Read data of port A |
| rd_word_b | output | 32 | Read data of port B |

## Verification
The hardest case to reach from the ports is a same-cycle collision where a write and one or both reads name the same register. The forwarding must win over the stale stored word, except when the register is 0 or the write is blocked by reset. The stimulus forces these collisions directly: both ports read the register being written, register 0 is written with a nonzero word while it is read, and a write to an already known register is driven while reset is high. Random traffic then draws the addresses from a small pool so that collisions recur often. Every read is compared against a behavioural model that tracks which registers hold known values.

// File: rtl/trio_rf_pkg.sv
package trio_rf_pkg;

    localparam int RF_DEF_DATA_W = 32;
    localparam int RF_DEF_N_REGS = 32;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_FWD   = 2'd1,
        SRC_ARRAY = 2'd2
    } rd_src_e;

    function automatic int rf_addr_bits(input int n_regs);
        return (n_regs < 2) ? 1 : $clog2(n_regs);
    endfunction

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
    parameter int N_REGS = 32,
    parameter int ADDR_W = 5
) (
    input  logic              fire,
    input  logic [ADDR_W-1:0] idx,
    output logic [N_REGS-1:0] sel
);

    assign sel[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 1; gi < N_REGS; gi++) begin : g_dec
            assign sel[gi] = fire && (idx == ADDR_W'(gi));
        end
    endgenerate

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int N_REGS = 32,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_REGS-1:0]        sel,
    input  logic [DATA_W-1:0]        din,
    output logic [N_REGS*DATA_W-1:0] flat
);

    assign flat[DATA_W-1:0] = '0;

    genvar gi;
    generate
        for (gi = 1; gi < N_REGS; gi++) begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (sel[gi]) begin
                    q <= din;
                end
            end
            assign flat[gi*DATA_W +: DATA_W] = q;

            // R2: a selected write lands in this register at the edge
            a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
                sel[gi] |=> (q == $past(din)));
        end
    endgenerate

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import trio_rf_pkg::*;
#(
    parameter int N_REGS = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_REGS*DATA_W-1:0] flat,
    input  logic [ADDR_W-1:0]        idx,
    input  logic                     fwd_fire,
    input  logic [ADDR_W-1:0]        fwd_idx,
    input  logic [DATA_W-1:0]        fwd_word,
    output logic [DATA_W-1:0]        word
);

    logic [DATA_W-1:0] arr [N_REGS];
    logic [DATA_W-1:0] picked;
    rd_src_e           src;

    genvar gi;
    generate
        for (gi = 0; gi < N_REGS; gi++) begin : g_unpack
            assign arr[gi] = flat[gi*DATA_W +: DATA_W];
        end
    endgenerate

    always_comb begin
        picked = '0;
        for (int k = 0; k < N_REGS; k++) begin
            if (idx == ADDR_W'(k)) begin
                picked = arr[k];
            end
        end
    end

    always_comb begin
        if (idx == '0) begin
            src = SRC_ZERO;
        end else if (fwd_fire && (fwd_idx == idx)) begin
            src = SRC_FWD;
        end else begin
            src = SRC_ARRAY;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ZERO:  word = '0;
            SRC_FWD:   word = fwd_word;
            default:   word = picked;
        endcase
    end

    // R3 and R5: register 0 reads zero even while it is being written
    a_r3_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (idx == '0) |-> (word == '0));

    // R4: a same-cycle write to the read register is forwarded
    a_r4_forward_new_word: assert property (@(posedge clk) disable iff (rst)
        (fwd_fire && (fwd_idx == idx) && (idx != '0)) |-> (word == fwd_word));

endmodule

// File: rtl/trio_regfile.sv
module trio_regfile
    import trio_rf_pkg::*;
#(
    parameter int DATA_W = RF_DEF_DATA_W,
    parameter int N_REGS = RF_DEF_N_REGS,
    parameter int ADDR_W = rf_addr_bits(RF_DEF_N_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_idx_a,
    input  logic [ADDR_W-1:0] rd_idx_b,
    output logic [DATA_W-1:0] rd_word_a,
    output logic [DATA_W-1:0] rd_word_b
);

    localparam int N_RD = 2;

    logic                     wr_fire;
    logic [N_REGS-1:0]        wr_sel;
    logic [N_REGS*DATA_W-1:0] flat;
    logic [ADDR_W-1:0]        rd_idx  [N_RD];
    logic [DATA_W-1:0]        rd_word [N_RD];

    assign wr_fire   = wr_en && !rst;
    assign rd_idx[0] = rd_idx_a;
    assign rd_idx[1] = rd_idx_b;
    assign rd_word_a = rd_word[0];
    assign rd_word_b = rd_word[1];

    rf_write_decode #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u_dec (
        .fire (wr_fire),
        .idx  (wr_idx),
        .sel  (wr_sel)
    );

    rf_storage #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .sel  (wr_sel),
        .din  (wr_word),
        .flat (flat)
    );

    genvar gp;
    generate
        for (gp = 0; gp < N_RD; gp++) begin : g_rd
            rf_read_port #(.N_REGS(N_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
                .clk      (clk),
                .rst      (rst),
                .flat     (flat),
                .idx      (rd_idx[gp]),
                .fwd_fire (wr_fire),
                .fwd_idx  (wr_idx),
                .fwd_word (wr_word),
                .word     (rd_word[gp])
            );
        end
    endgenerate

    // R1: the two read ports agree whenever they name the same register
    a_r1_ports_agree: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> (rd_word_a === rd_word_b));

endmodule

// File: tb/trio_regfile_bench.sv
`timescale 1ns/10ps
module trio_regfile_bench;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_word = '0;
    logic [4:0]  rd_idx_a = '0;
    logic [4:0]  rd_idx_b = '0;
    logic [31:0] rd_word_a;
    logic [31:0] rd_word_b;

    int tests = 0;
    int fails = 0;

    logic [31:0] model [32];
    bit          known [32];

    always #(HALF) clk = ~clk;

    trio_regfile u_trio_regfile (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_word   (wr_word),
        .rd_idx_a  (rd_idx_a),
        .rd_idx_b  (rd_idx_b),
        .rd_word_a (rd_word_a),
        .rd_word_b (rd_word_b)
    );

    task automatic check_port(input int addr, input logic [31:0] got,
                              input string tag, input string port);
        logic [31:0] exp;
        string       t;
        t = tag;
        if (addr == 0) begin
            exp = 32'h0;
            if (t == "") t = "R3";
        end else if (wr_en && !rst && (wr_idx == 5'(addr))) begin
            exp = wr_word;
            if (t == "") t = "R4";
        end else if (known[addr]) begin
            exp = model[addr];
            if (t == "") t = "R2";
        end else begin
            return;
        end
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s port %s reg %0d: got %h expected %h", t, port, addr, got, exp);
        end
    endtask

    task automatic step(input logic r, input logic w, input int wa, input logic [31:0] wd,
                        input int a, input int b, input string tag);
        @(negedge clk);
        rst = r; wr_en = w; wr_idx = 5'(wa); wr_word = wd;
        rd_idx_a = 5'(a); rd_idx_b = 5'(b);
        #1;
        check_port(a, rd_word_a, tag, "A");
        check_port(b, rd_word_b, tag, "B");
        @(posedge clk);
        if (w && !r && wa != 0) begin
            model[wa] = wd;
            known[wa] = 1'b1;
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        fails++;
        $display("FAIL watchdog R1: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            known[i] = 1'b0;
            model[i] = '0;
        end

        // R3: register 0 reads zero during reset
        step(1'b1, 1'b0, 0, 32'h0, 0, 0, "R3");
        step(1'b1, 1'b1, 0, 32'hFFFF_FFFF, 0, 0, "R3");

        // R1 and R2: fill every register, read each back on both ports
        for (int i = 1; i < 32; i++) begin
            step(1'b0, 1'b1, i, 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101), 0, 0, "R2");
        end
        for (int i = 1; i < 32; i++) begin
            step(1'b0, 1'b0, 0, 32'h0, i, 32 - i, "R1");
        end

        // R4: both ports read the register being written
        step(1'b0, 1'b1, 9, 32'hDEAD_BEEF, 9, 9, "R4");
        step(1'b0, 1'b0, 0, 32'h0, 9, 3, "R4");
        step(1'b0, 1'b1, 31, 32'h1234_5678, 31, 30, "R4");

        // R5: write to register 0 with a nonzero word while reading it
        step(1'b0, 1'b1, 0, 32'hCAFE_F00D, 0, 0, "R5");
        step(1'b0, 1'b0, 0, 32'h0, 0, 1, "R5");

        // R6: disabled writes change nothing
        for (int i = 1; i < 32; i++) begin
            step(1'b0, 1'b0, i, ~model[i], i, (i + 7) % 32, "R6");
        end

        // R8: reset blocks write and forwarding, keeps contents
        step(1'b1, 1'b1, 7, 32'h0BAD_0BAD, 7, 7, "R8");
        step(1'b1, 1'b1, 12, 32'h7777_7777, 12, 0, "R8");
        step(1'b0, 1'b0, 0, 32'h0, 7, 12, "R8");

        // R7: addresses change within one low phase, no clock edge
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 1; i < 32; i++) begin
            rd_idx_a = 5'(i);
            rd_idx_b = 5'(31 - i);
            #0.05;
            check_port(i, rd_word_a, "R7", "A");
            check_port(31 - i, rd_word_b, "R7", "B");
        end

        // random traffic on a small address pool to make collisions common
        for (int n = 0; n < 600; n++) begin
            int pool [6];
            pool = '{0, 1, 2, 3, 17, 31};
            step(($urandom % 16) == 0, ($urandom % 3) != 0,
                 pool[$urandom % 6], $urandom,
                 pool[$urandom % 6], pool[$urandom % 6], "");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule